// File: doc/BRIEF.md
# Palette Loader and Format Converter

This block fills a colour lookup table for an indexed-colour display pipeline. A frame fetcher streams raw palette words into it over a valid/ready handshake. The block stores those words unchanged, then expands each stored entry into a normalised form: 8-bit red, green and blue plus one transparency bit. Downstream pixel logic reads the table through an asynchronous read port that takes the pixel value as its address.

The pixel depth sets the table size. The 2-bit format selector picks one of four source layouts: a packed 16-bit layout, or one of three 32-bit layouts that carry a transparency flag and 16, 18 or 24 bits of colour. A monochrome flag copies the entry's low byte into all three channels. The raw words stay stored, so if software changes the format selector after a load, the block rebuilds the table from those words without fetching them again.

The controller has three states. IDLE waits. LOAD accepts words. PARSE converts one entry per cycle. There are four transitions. *Load-start* (IDLE to LOAD) fires on `start` with a supported depth. *Format-mismatch* (IDLE to PARSE) fires with no `start`, a palette already built, and `fmt_sel` different from the format of the last parse. *Last-word* (LOAD to PARSE) fires when the final word is accepted. *Last-entry* (PARSE to IDLE) fires when the final entry is written.

Top module: `pal_loader`

## Requirements
- R1: Depth code 1, 2 and 3 select 4, 16 and 256 entries. In format 0 a load accepts half that many 32-bit words; in formats 1 to 3 it accepts one word per entry. `in_ready` is high only while words are still owed.
- R2: A `start` with depth code 0 or 4 to 7 accepts no words and leaves every stored entry unchanged. It also clears `done`.
- R3: In format 0, each word holds two 16-bit entries, lower halfword first. Red is bits [15:11] and blue is bits [4:0], each placed in the top of 8 bits. Green is bits [10:5] placed in the top of 8 bits. Transparency is always 0.
- R4: In format 1, red is word bits [23:19], green is bits [15:10] and blue is bits [7:3]. Each is left-aligned, and the low bits are zero.
- R5: In format 2, red is word bits [23:18], green is bits [15:10] and blue is bits [7:2]. Each is left-aligned, and the low two bits are zero.
- R6: In format 3, red is word bits [23:16], green is bits [15:8] and blue is bits [7:0].
- R7: In formats 1 to 3, the transparency bit of an entry equals word bit 24.
- R8: With the monochrome flag set, red, green and blue all equal the low 8 bits of the entry. For format 0 this is the halfword's low byte. Transparency still follows R3 and R7.
- R9: Entry k (counting from 0) is readable k+1 cycles after the cycle that accepted the last word. `done` rises together with the final entry, stays high, and falls in the cycle after an accepted `start` or a re-parse trigger.
- R10: In IDLE, with a built palette, no `start`, and `fmt_sel` different from the format of the last parse, the block rebuilds all entries from the stored words. It uses the new format and the monochrome flag present at that moment. This takes one cycle per entry, accepts no words, and ends with `done` high.
- R11: After reset, `done` and `in_ready` are low and every entry reads as all zeros.
- R12: A `start` during LOAD or PARSE is ignored. The load in progress keeps its depth and format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a load; sampled in IDLE only |
| depth_code | input | 3 | Pixel depth code (1, 2, 3 supported) |
| fmt_sel | input | 2 | Source entry format 0..3 |
| mono | input | 1 | Monochrome replication flag |
| in_valid | input | 1 | Raw palette word valid |
| in_data | input | 32 | Raw palette word |
| in_ready | output | 1 | Block accepts a word this cycle |
| rd_idx | input | 8 | Table read address (pixel value) |
| rd_red | output | 8 | Red of addressed entry |
| rd_green | output | 8 | Green of addressed entry |
| rd_blue | output | 8 | Blue of addressed entry |
| rd_transp | output | 1 | Transparency of addressed entry |
| done | output | 1 | Table complete |

## Verification
- Timing of `in_ready`: it rises one cycle after an accepted `start` and falls in the cycle after the last word is taken.
- Timing of entries and `done`: entry k changes k+1 cycles after the last word or after the re-parse trigger. The read port has no register, so an entry is visible in the cycle after it is written, for whatever `rd_idx` selects. `done` rises with the final write.
- How the bench checks this: a behavioural model steps once per rising edge, using the inputs held stable across that edge. The bench compares `in_ready`, `done` and the addressed entry with the model two time units after every edge. Inputs change only on falling edges, so every result is sampled in the exact cycle it is due.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int RAW_W = 32;

    typedef enum logic [1:0] {
        PST_IDLE,
        PST_LOAD,
        PST_PARSE
    } pal_state_e;

    typedef enum logic [1:0] {
        PFMT_P16 = 2'd0,
        PFMT_T16 = 2'd1,
        PFMT_T18 = 2'd2,
        PFMT_T24 = 2'd3
    } pal_fmt_e;

    typedef struct packed {
        logic       transp;
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } pal_entry_t;

    localparam int ENTRY_W = $bits(pal_entry_t);

    // Depth codes 1..3 mean 2, 4 and 8 bits per pixel.
    function automatic logic depth_supported(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd3);
    endfunction

    // Table size is two to the power of the bits per pixel.
    function automatic int unsigned entry_count(input logic [2:0] code);
        int unsigned bpp;
        if (!depth_supported(code)) begin
            return 0;
        end
        bpp = 32'd1 << code;
        return 32'd1 << bpp;
    endfunction

endpackage

// File: rtl/pal_regfile.sv
module pal_regfile #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pal_fmt_conv.sv
module pal_fmt_conv
    import pal_pkg::*;
(
    input  logic [RAW_W-1:0] raw_word,
    input  logic             half_hi,
    input  pal_fmt_e         fmt,
    input  logic             mono,
    output pal_entry_t       entry
);

    logic [15:0] half;
    logic [7:0]  low_byte;

    assign half     = half_hi ? raw_word[31:16] : raw_word[15:0];
    assign low_byte = (fmt == PFMT_P16) ? half[7:0] : raw_word[7:0];

    always_comb begin
        entry = '0;
        unique case (fmt)
            PFMT_P16: begin
                entry.red    = {half[15:11], 3'b000};
                entry.green  = {half[10:5], 2'b00};
                entry.blue   = {half[4:0], 3'b000};
                entry.transp = 1'b0;
            end
            PFMT_T16: begin
                entry.red    = {raw_word[23:19], 3'b000};
                entry.green  = {raw_word[15:10], 2'b00};
                entry.blue   = {raw_word[7:3], 3'b000};
                entry.transp = raw_word[24];
            end
            PFMT_T18: begin
                entry.red    = {raw_word[23:18], 2'b00};
                entry.green  = {raw_word[15:10], 2'b00};
                entry.blue   = {raw_word[7:2], 2'b00};
                entry.transp = raw_word[24];
            end
            PFMT_T24: begin
                entry.red    = raw_word[23:16];
                entry.green  = raw_word[15:8];
                entry.blue   = raw_word[7:0];
                entry.transp = raw_word[24];
            end
            default: entry = '0;
        endcase
        if (mono) begin
            entry.red   = low_byte;
            entry.green = low_byte;
            entry.blue  = low_byte;
        end
    end

endmodule

// File: rtl/pal_loader.sv
module pal_loader
    import pal_pkg::*;
#(
    parameter int MAX_ENTRIES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  depth_code,
    input  logic [1:0]  fmt_sel,
    input  logic        mono,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    input  logic [7:0]  rd_idx,
    output logic [7:0]  rd_red,
    output logic [7:0]  rd_green,
    output logic [7:0]  rd_blue,
    output logic        rd_transp,
    output logic        done
);

    localparam int IDX_W = $clog2(MAX_ENTRIES);
    localparam int CNT_W = IDX_W + 1;

    pal_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nent_q;
    pal_fmt_e         fmt_q;
    logic             mono_q;
    logic             done_q;
    logic             loaded_q;

    logic [CNT_W-1:0] words_need;
    logic             go_load, go_reparse, word_take, word_last, ent_last;
    logic             raw_we, ent_we;
    logic [IDX_W-1:0] raw_raddr;
    logic [RAW_W-1:0] raw_rdata;
    pal_entry_t       ent_wdata, ent_rdata;
    pal_fmt_e         fmt_in;

    assign fmt_in     = pal_fmt_e'(fmt_sel);
    assign words_need = (fmt_q == PFMT_P16) ? (nent_q >> 1) : nent_q;
    assign go_load    = start && depth_supported(depth_code);
    assign go_reparse = !start && loaded_q && (fmt_in != fmt_q);
    assign word_take  = (state_q == PST_LOAD) && in_valid;
    assign word_last  = cnt_q == (words_need - CNT_W'(1));
    assign ent_last   = cnt_q == (nent_q - CNT_W'(1));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PST_IDLE: begin
                if (go_load) begin
                    state_d = PST_LOAD;
                end else if (go_reparse) begin
                    state_d = PST_PARSE;
                end
            end
            PST_LOAD: begin
                if (word_take && word_last) begin
                    state_d = PST_PARSE;
                end
            end
            PST_PARSE: begin
                if (ent_last) begin
                    state_d = PST_IDLE;
                end
            end
            default: state_d = PST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            nent_q   <= '0;
            fmt_q    <= PFMT_P16;
            mono_q   <= 1'b0;
            done_q   <= 1'b0;
            loaded_q <= 1'b0;
        end else begin
            unique case (state_q)
                PST_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        if (go_load) begin
                            nent_q <= CNT_W'(entry_count(depth_code));
                            fmt_q  <= fmt_in;
                            mono_q <= mono;
                            cnt_q  <= '0;
                        end
                    end else if (go_reparse) begin
                        fmt_q  <= fmt_in;
                        mono_q <= mono;
                        cnt_q  <= '0;
                        done_q <= 1'b0;
                    end
                end
                PST_LOAD: begin
                    if (word_take) begin
                        cnt_q <= word_last ? '0 : cnt_q + CNT_W'(1);
                    end
                end
                PST_PARSE: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (ent_last) begin
                        done_q   <= 1'b1;
                        loaded_q <= 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // Outputs and strobes
    always_comb begin
        in_ready  = (state_q == PST_LOAD);
        raw_we    = word_take;
        ent_we    = (state_q == PST_PARSE);
        raw_raddr = (fmt_q == PFMT_P16) ? cnt_q[IDX_W:1] : cnt_q[IDX_W-1:0];
    end

    pal_regfile #(
        .WIDTH (RAW_W),
        .DEPTH (MAX_ENTRIES)
    ) u_raw_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (raw_we),
        .waddr (cnt_q[IDX_W-1:0]),
        .wdata (in_data),
        .raddr (raw_raddr),
        .rdata (raw_rdata)
    );

    pal_fmt_conv u_conv (
        .raw_word (raw_rdata),
        .half_hi  (cnt_q[0]),
        .fmt      (fmt_q),
        .mono     (mono_q),
        .entry    (ent_wdata)
    );

    pal_regfile #(
        .WIDTH (ENTRY_W),
        .DEPTH (MAX_ENTRIES)
    ) u_entry_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ent_we),
        .waddr (cnt_q[IDX_W-1:0]),
        .wdata (ent_wdata),
        .raddr (rd_idx[IDX_W-1:0]),
        .rdata (ent_rdata)
    );

    assign rd_red    = ent_rdata.red;
    assign rd_green  = ent_rdata.green;
    assign rd_blue   = ent_rdata.blue;
    assign rd_transp = ent_rdata.transp;
    assign done      = done_q;

    AST_WORDS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PST_LOAD) |-> (cnt_q < words_need)); // R1

    AST_BAD_DEPTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PST_IDLE && start && !depth_supported(depth_code))
        |=> (state_q == PST_IDLE && !in_ready)); // R2

    AST_P16_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_we && fmt_q == PFMT_P16) |-> !ent_wdata.transp); // R3

    AST_MONO_GREY: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_we && mono_q) |-> (ent_wdata.red == ent_wdata.green
                                && ent_wdata.green == ent_wdata.blue)); // R8

    AST_DONE_FROM_PARSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state_q) == PST_PARSE)); // R9

    AST_REPARSE_ON_FMT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PST_IDLE && go_reparse)
        |=> (state_q == PST_PARSE && !done)); // R10

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PST_IDLE && start) |=> $stable(nent_q)); // R12

endmodule

// File: tb/pal_loader_tb.sv
module pal_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  depth_code = 3'd1;
    logic [1:0]  fmt_sel = 2'd0;
    logic        mono = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic [7:0]  rd_idx = '0;
    logic [7:0]  rd_red, rd_green, rd_blue;
    logic        rd_transp;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    string ctx  = "";
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    pal_loader u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .depth_code (depth_code),
        .fmt_sel    (fmt_sel),
        .mono       (mono),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .rd_idx     (rd_idx),
        .rd_red     (rd_red),
        .rd_green   (rd_green),
        .rd_blue    (rd_blue),
        .rd_transp  (rd_transp),
        .done       (done)
    );

    // Behavioural reference model
    logic [31:0] m_raw [256];
    logic [24:0] m_pal [256];
    int          m_phase;   // 0 idle, 1 taking words, 2 building
    int          m_n, m_words, m_k, m_fmt;
    bit          m_mono, m_done, m_built;

    function automatic logic [24:0] mdl_conv(input logic [31:0] v, input int f, input bit m);
        int r, g, b, t;
        case (f)
            0: begin r = ((v >> 11) & 31) * 8; g = ((v >> 5) & 63) * 4; b = (v & 31) * 8; t = 0; end
            1: begin r = ((v >> 19) & 31) * 8; g = ((v >> 10) & 63) * 4; b = ((v >> 3) & 31) * 8; t = (v >> 24) & 1; end
            2: begin r = ((v >> 18) & 63) * 4; g = ((v >> 10) & 63) * 4; b = ((v >> 2) & 63) * 4; t = (v >> 24) & 1; end
            default: begin r = (v >> 16) & 255; g = (v >> 8) & 255; b = v & 255; t = (v >> 24) & 1; end
        endcase
        if (m) begin r = v & 255; g = r; b = r; end
        return {t[0], r[7:0], g[7:0], b[7:0]};
    endfunction

    function automatic logic [31:0] mdl_src(input int k, input int f);
        if (f == 0) return (m_raw[k / 2] >> (16 * (k % 2))) & 32'hffff;
        return m_raw[k];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic string ent_tag();
        if (ctx == "R11" || ctx == "R2" || ctx == "R10") return ctx;
        if (m_mono) return "R8";
        case (m_fmt)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin m_raw[i] = '0; m_pal[i] = '0; end
            m_phase = 0; m_n = 0; m_words = 0; m_k = 0; m_fmt = 0;
            m_mono = 0; m_done = 0; m_built = 0;
        end else begin
            case (m_phase)
                0: begin
                    if (start) begin
                        m_done = 0;
                        if (depth_code >= 1 && depth_code <= 3) begin
                            m_n     = 1 << (1 << depth_code);
                            m_fmt   = int'(fmt_sel);
                            m_mono  = mono;
                            m_words = (m_fmt == 0) ? m_n / 2 : m_n;
                            m_k     = 0;
                            m_phase = 1;
                        end
                    end else if (m_built && int'(fmt_sel) != m_fmt) begin
                        m_fmt = int'(fmt_sel); m_mono = mono; m_k = 0; m_done = 0; m_phase = 2;
                    end
                end
                1: begin
                    if (in_valid) begin
                        m_raw[m_k] = in_data;
                        m_k++;
                        if (m_k == m_words) begin m_k = 0; m_phase = 2; end
                    end
                end
                default: begin
                    m_pal[m_k] = mdl_conv(mdl_src(m_k, m_fmt), m_fmt, m_mono);
                    m_k++;
                    if (m_k == m_n) begin m_phase = 0; m_done = 1; m_built = 1; end
                end
            endcase
        end
        #2;
        chk((ctx != "") ? ctx : "R1", {31'd0, in_ready}, {31'd0, m_phase == 1});
        chk((ctx != "") ? ctx : "R9", {31'd0, done}, {31'd0, m_done});
        chk(ent_tag(), {8'd0, rd_red, rd_green, rd_blue}, {8'd0, m_pal[rd_idx][23:0]});
        chk((ctx == "R11" || ctx == "R2" || ctx == "R10") ? ctx : ((m_fmt == 0) ? "R3" : "R7"),
            {31'd0, rd_transp}, {31'd0, m_pal[rd_idx][24]});
    end

    task automatic sweep(input int n);
        for (int i = 0; i < n; i++) begin
            rd_idx = 8'(i);
            @(negedge clk);
        end
    endtask

    task automatic load(input logic [2:0] dc, input logic [1:0] fs, input logic mn,
                        input bit gap, input int poke);
        int n, nw;
        n  = 1 << (1 << dc);
        nw = (fs == 2'd0) ? n / 2 : n;
        @(negedge clk);
        depth_code = dc; fmt_sel = fs; mono = mn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < nw; i++) begin
            while (!in_ready) @(negedge clk);
            seed = seed * 32'd1664525 + 32'd1013904223;
            in_data = seed;
            in_data[24] = i[0];
            in_valid = 1'b1;
            if (i == poke) begin start = 1'b1; depth_code = 3'd3; end
            @(negedge clk);
            start = 1'b0; depth_code = dc;
            if (gap && i[0]) begin in_valid = 1'b0; @(negedge clk); end
        end
        in_valid = 1'b0;
        while (!done) @(negedge clk);
        sweep(n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state of every entry
        ctx = "R11";
        sweep(256);
        ctx = "";
        load(3'd1, 2'd0, 1'b0, 1'b0, -1);  // R3 packed halfwords
        load(3'd2, 2'd1, 1'b0, 1'b1, -1);  // R4 R7 with gaps
        load(3'd2, 2'd2, 1'b0, 1'b0, -1);  // R5
        load(3'd3, 2'd3, 1'b0, 1'b1, -1);  // R6 full table
        load(3'd2, 2'd3, 1'b1, 1'b0, -1);  // R8 mono
        load(3'd1, 2'd0, 1'b1, 1'b0, -1);  // R8 mono from halfword
        // R2: unsupported depth codes take no words
        ctx = "R2";
        @(negedge clk);
        depth_code = 3'd0; start = 1'b1; in_valid = 1'b1; in_data = 32'hffff_ffff;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        depth_code = 3'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        sweep(4);
        // R12: start during a load is ignored
        ctx = "R12";
        load(3'd2, 2'd3, 1'b0, 1'b0, 3);
        // R10: re-parse on format change
        ctx = "R10";
        @(negedge clk);
        fmt_sel = 2'd0;
        @(negedge clk);
        while (!done) @(negedge clk);
        sweep(16);
        fmt_sel = 2'd2; mono = 1'b1;
        @(negedge clk);
        while (!done) @(negedge clk);
        sweep(16);
        fmt_sel = 2'd1; mono = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
        sweep(16);
        ctx = "";
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule